// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one unsigned word by another and returns the quotient and the remainder. It computes one quotient bit per clock cycle. The work is held in a single shifting register. Its upper part carries the partial remainder, and its lower part starts with the dividend and fills with quotient bits as the dividend moves out. Each cycle makes one trial subtraction of the divisor from the upper part. The divisor is subtracted only when the partial remainder is large enough. Otherwise the old upper part is kept, which is the restoring choice. The new quotient bit is the one that enters at the bottom of the register.

A caller waits until `busy_o` is low, then presents both operands with a one-cycle `start_i`. `busy_o` stays high while the divider iterates. `done_o` pulses for exactly one cycle when `quotient_o` and `remainder_o` are valid. Both results then stay unchanged until the next accepted start. A zero divisor is not trapped. It gives an all-ones quotient and returns the dividend as the remainder.

Top module: `seq_divider`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, and `quotient_o` and `remainder_o` are 0.
- R2: A `start_i` seen while `busy_o` is low is accepted at that clock edge. `busy_o` is 1 and `done_o` is 0 in the following cycle.
- R3: `done_o` is high for exactly one cycle. It rises at the WIDTH+1-th rising edge that counts the accepting edge as the first (33 edges for WIDTH=32). `busy_o` falls at that same edge.
- R4: When the divisor is non-zero and `done_o` is high, `quotient_o` equals floor(dividend/divisor) and `remainder_o` equals dividend mod divisor. Both operands are unsigned.
- R5: When the divisor is non-zero, the reported remainder is strictly below the divisor.
- R6: A divisor of 0 gives a quotient with every bit set to 1 and a remainder equal to the dividend, with no other indication.
- R7: `start_i` and operand changes while `busy_o` is high are ignored. The running operation keeps its latency and its result.
- R8: While `busy_o` is low and no start is accepted, `quotient_o` and `remainder_o` do not change.
- R9: Divisors with the most significant bit set, and partial remainders that reach the full word width before subtraction, give correct results (R4 still holds).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a division; taken only when idle |
| dividend_i | input | WIDTH | Unsigned dividend, sampled at the accepting edge |
| divisor_i | input | WIDTH | Unsigned divisor, sampled at the accepting edge |
| busy_o | output | 1 | High while the iterations run |
| done_o | output | 1 | One-cycle pulse when the results are valid |
| quotient_o | output | WIDTH | Unsigned quotient |
| remainder_o | output | WIDTH | Unsigned remainder |

## Verification
The bench targets divisors with the top bit set. A design that tests the sign with only a word-wide difference drops the carry out of the doubled partial remainder, and its results break there. Zero divisors and equal operands check that the final halving of the upper part is applied exactly once: an off-by-one in the shift count returns a doubled or halved remainder. The bench also pokes `start_i` with other operands in the middle of a run, which catches a design that reloads while busy. Finally it counts the cycles from acceptance to `done_o`, so a loop of 31 or 33 iterations shows up as a latency error even where the data happens to match.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    typedef enum logic [0:0] {
        SD_IDLE = 1'b0,
        SD_RUN  = 1'b1
    } sdiv_state_e;

endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
    import sdiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(WIDTH - 1);

    typedef struct packed {
        sdiv_state_e      state;
        logic [CNT_W-1:0] iter;
        logic             done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        case (ctrl_q.state)
            SD_IDLE: begin
                if (start_i) begin
                    ctrl_d.state = SD_RUN;
                    ctrl_d.iter  = '0;
                end
            end
            SD_RUN: begin
                if (ctrl_q.iter == LAST_ITER) begin
                    ctrl_d.state = SD_IDLE;
                    ctrl_d.done  = 1'b1;
                end else begin
                    ctrl_d.iter = ctrl_q.iter + 1'b1;
                end
            end
            default: ctrl_d.state = SD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{state: SD_IDLE, iter: '0, done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign load_o = (ctrl_q.state == SD_IDLE) && start_i;
    assign step_o = (ctrl_q.state == SD_RUN);
    assign busy_o = (ctrl_q.state == SD_RUN);
    assign done_o = ctrl_q.done;

    AST_START_GIVES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R3

    AST_BUSY_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ctrl_q.iter != LAST_ITER) |=> (busy_o && !done_o)); // R7

endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH:0]   upper_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             fits_o,
    output logic [WIDTH:0]   upper_next_o
);

    localparam int DIFF_W = WIDTH + 2;

    logic [DIFF_W-1:0] trial;

    always_comb begin
        trial        = {1'b0, upper_i} - {2'b00, divisor_i};
        fits_o       = ~trial[DIFF_W-1];
        upper_next_o = fits_o ? trial[WIDTH:0] : upper_i;
    end

endmodule

// File: rtl/sdiv_work.sv
module sdiv_work #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic [WIDTH-1:0] divisor_o,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o
);

    localparam int ACC_W = 2 * WIDTH + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [WIDTH-1:0] dvs;
    } work_t;

    work_t work_d, work_q;

    logic             fits;
    logic [WIDTH:0]   upper_next;

    sdiv_step #(.WIDTH(WIDTH)) u_step (
        .upper_i      (work_q.acc[ACC_W-1:WIDTH]),
        .divisor_i    (work_q.dvs),
        .fits_o       (fits),
        .upper_next_o (upper_next)
    );

    always_comb begin
        work_d = work_q;
        if (load_i) begin
            work_d.acc = {{WIDTH{1'b0}}, dividend_i, 1'b0};
            work_d.dvs = divisor_i;
        end else if (step_i) begin
            work_d.acc = {upper_next[WIDTH-1:0], work_q.acc[WIDTH-1:0], fits};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
        end else begin
            work_q <= work_d;
        end
    end

    assign divisor_o   = work_q.dvs;
    assign quotient_o  = work_q.acc[WIDTH-1:0];
    assign remainder_o = work_q.acc[ACC_W-1:WIDTH+1];

    AST_OPERAND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> $stable(work_q.dvs)); // R7

    AST_NO_LOAD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> !load_i); // R7

endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o
);

    logic             load;
    logic             step;
    logic [WIDTH-1:0] held_divisor;

    sdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    sdiv_work #(.WIDTH(WIDTH)) u_work (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .step_i      (step),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .divisor_o   (held_divisor),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o)
    );

    AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && held_divisor != '0) |-> (remainder_o < held_divisor)); // R5

    AST_ZERO_DIV_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && held_divisor == '0) |-> (quotient_o == '1)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o))); // R8

endmodule

// File: tb/seq_divider_tb.sv
module seq_divider_tb;

    localparam int W = 32;
    localparam time CLK_PERIOD = 10ns;
    localparam int LATENCY = W + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] quotient_o, remainder_o;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        int unsigned  t0;
        string        req;
    } exp_t;

    exp_t sb[$];

    int unsigned cyc = 0;
    int checks = 0;
    int errors = 0;
    logic         done_seen_prev = 1'b0;
    logic [W-1:0] last_q = '0, last_r = '0;

    seq_divider #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .busy_o(busy_o), .done_o(done_o),
        .quotient_o(quotient_o), .remainder_o(remainder_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // driver: waits for idle, issues one division, pushes the expectation
    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        exp_t e;
        while (busy_o) @(negedge clk);
        dividend_i = a;
        divisor_i  = b;
        start_i    = 1'b1;
        if (b == '0) begin
            e.q = '1;   // R6
            e.r = a;
        end else begin
            e.q = a / b;
            e.r = a % b;
        end
        e.t0  = cyc;
        e.req = req;
        sb.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R2", "busy after start", W'(busy_o), W'(1));
        check(done_o === 1'b0, "R2", "done after start", W'(done_o), W'(0));
    endtask

    // monitor: pops the expectation on each done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_seen_prev)
                check(done_o === 1'b0, "R3", "done width", W'(done_o), W'(0));
            if (done_o) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R3", "unexpected done", W'(1), W'(0));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(quotient_o === e.q, e.req, "quotient", quotient_o, e.q);
                    check(remainder_o === e.r, e.req, "remainder", remainder_o, e.r);
                    check(cyc - e.t0 == LATENCY, "R3", "latency",
                          W'(cyc - e.t0), W'(LATENCY));
                    check(busy_o === 1'b0, "R3", "busy at done", W'(busy_o), W'(0));
                    last_q = quotient_o;
                    last_r = remainder_o;
                end
            end
            done_seen_prev = done_o;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy_o === 1'b0, "R1", "busy in reset", W'(busy_o), W'(0));
        check(done_o === 1'b0, "R1", "done in reset", W'(done_o), W'(0));
        check(quotient_o === '0, "R1", "quotient in reset", quotient_o, W'(0));
        check(remainder_o === '0, "R1", "remainder in reset", remainder_o, W'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R4: ordinary cases
        run_div(32'd100, 32'd7, "R4");
        run_div(32'd9, 32'd8, "R4");
        run_div(32'd5, 32'd9, "R4");
        run_div(32'd12345, 32'd12345, "R4");
        run_div(32'd0, 32'd3, "R4");
        run_div(32'hFFFF_FFFF, 32'd1, "R4");
        // R6: zero divisor
        run_div(32'hDEAD_BEEF, 32'd0, "R6");
        run_div(32'd0, 32'd0, "R6");
        // R9: wide divisors and large partial remainders
        run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9");
        run_div(32'hFFFF_FFFE, 32'hFFFF_FFFF, "R9");
        run_div(32'hFFFF_FFFF, 32'h8000_0001, "R9");
        run_div(32'hF000_0000, 32'hC000_0001, "R9");
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] a, b;
            a = $urandom();
            b = (i % 3 == 0) ? ($urandom() | 32'h8000_0000) : ($urandom() >> (i % 31));
            run_div(a, b, (b[W-1]) ? "R9" : "R4");
        end

        // R7: start with other operands while busy is ignored
        run_div(32'd1000, 32'd33, "R7");
        repeat (10) @(negedge clk);
        dividend_i = 32'd77;
        divisor_i  = 32'd0;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;

        // R8: outputs hold while idle
        while (sb.size() != 0 || busy_o) @(negedge clk);
        repeat (6) @(negedge clk);
        check(quotient_o === last_q, "R8", "quotient held", quotient_o, last_q);
        check(remainder_o === last_r, "R8", "remainder held", remainder_o, last_r);
        check(busy_o === 1'b0, "R7", "no extra run", W'(busy_o), W'(0));

        summary();
        $finish;
    end

endmodule